// File: doc/BRIEF.md
# Alarm Status Fault Combiner

This block folds a set of equipment health lines into one summary fault flag and drives three status outputs from it. Every health line reads 0 when healthy and 1 when failing. Three of them are monitored failures: transmit path, orderwire and transmit PLL lock. A fourth, the loop-test control, picks the companion signal that may veto those failures. With the switch away from the radio position (control = 1), the equipment fault line is the veto. In the radio position (control = 0), the return-path failure line is the veto. The veto exists so that a condition already flagged upstream does not raise a second alarm here.

A separate qualified equipment status reports the equipment fault line only while the diagnostic-defeat line is 0. Each input passes through a two-stage synchronizer. The outputs are registered after the combining logic, so every output changes exactly three clock edges after its inputs change, and no output glitches. An active-low synchronous reset returns all outputs to the healthy state.

Top module: `alarm_fault_combiner`

## Requirements
- R1: On a rising clock edge with `rst_n` = 0, the outputs go to the healthy state on that edge: `meter_drive_n_o` = 1, `oc_fault_o` = 0, `eqpt_status_o` = 0.
- R2: `eqpt_status_o` is 1 exactly when `eqpt_fault_i` = 1 and `diag_defeat_i` = 0. When `diag_defeat_i` = 1 it is 0.
- R3: With `loop_not_radio_i` = 1, the summary fault (`oc_fault_o`) is 1 exactly when at least one of `tx_fail_i`, `ow_fail_i`, `pll_alarm_i` is 1 and `eqpt_fault_i` = 0.
- R4: With `loop_not_radio_i` = 0, the summary fault is 1 exactly when at least one monitored failure is 1 and `ret_fail_i` = 0.
- R5: When all three monitored failures are 0, the summary fault is 0 whatever the other inputs are.
- R6: `meter_drive_n_o` is always the complement of `oc_fault_o`: 1 when healthy and 0 on fault.
- R7: When reset is inactive, each output reflects the input values presented three rising edges earlier: two synchronizer stages and one output register.
- R8: `ret_fail_i` has no effect on the summary with the switch away from radio, and `eqpt_fault_i` has no effect on the summary in the radio position.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| eqpt_fault_i | input | 1 | Equipment fault (1 = fault) |
| diag_defeat_i | input | 1 | Diagnostic-defeat qualifier (1 = inhibit equipment status) |
| tx_fail_i | input | 1 | Transmit path failure (monitored) |
| ow_fail_i | input | 1 | Orderwire failure (monitored) |
| pll_alarm_i | input | 1 | Transmit PLL lock alarm (monitored) |
| ret_fail_i | input | 1 | Return-path failure (radio-position veto) |
| loop_not_radio_i | input | 1 | Loop-test control, 1 = not radio, 0 = radio |
| meter_drive_n_o | output | 1 | Inverted summary for the meter panel |
| oc_fault_o | output | 1 | Open-circuit style fault, 1 = fault |
| eqpt_status_o | output | 1 | Qualified equipment fault status |

## Verification
The hardest behaviour to reach from the ports is a veto handing over while a failure is present. This happens when the loop-test control flips while a monitored failure and only one of the two vetoes are active, so the summary must follow the new mode after exactly three edges. The stimulus first holds each of the 128 input combinations long enough to settle. It then changes all inputs on every cycle, including the switch, and applies a reset pulse in the middle of that activity. A cycle-accurate behavioural model predicts every output on every clock, which covers each mode handover at its exact latency.

// File: rtl/afc_pkg.sv
package afc_pkg;

   localparam int unsigned AFC_IN_W = 7;

   typedef struct packed {
      logic eqpt;
      logic defeat;
      logic tx;
      logic ow;
      logic pll;
      logic ret;
      logic loop_nr;
   } afc_in_t;

   typedef struct packed {
      logic summary;
      logic eqpt_stat;
   } afc_core_t;

   localparam afc_in_t AFC_IN_IDLE = '0;

endpackage

// File: rtl/afc_sync.sv
module afc_sync #(
   parameter int unsigned WIDTH  = 7,
   parameter int unsigned STAGES = 2,
   parameter logic [WIDTH-1:0] RST_VAL = '0
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d_i,
   output logic [WIDTH-1:0] q_o
);

   localparam int unsigned LAST = STAGES - 1;

   if (STAGES < 2) begin : g_chk_stages
      $error("afc_sync: STAGES must be at least 2");
   end
   if (WIDTH < 1) begin : g_chk_width
      $error("afc_sync: WIDTH must be at least 1");
   end

   logic [WIDTH-1:0] chain [STAGES];

   for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= d_i;
         end
      end else begin : g_rest
         always_ff @(posedge clk) begin
            if (!rst_n) chain[s] <= RST_VAL;
            else        chain[s] <= chain[s-1];
         end
      end
   end

   assign q_o = chain[LAST];

endmodule

// File: rtl/afc_qualify.sv
module afc_qualify
   import afc_pkg::*;
#(
   parameter int unsigned MON_W = 3
) (
   input  afc_in_t   in_i,
   output afc_core_t core_o
);

   if (MON_W != 3) begin : g_chk_mon
      $error("afc_qualify: MON_W must match the monitored line count");
   end

   logic [MON_W-1:0] mon;
   logic             mon_any;
   logic             veto;

   assign mon     = {in_i.tx, in_i.ow, in_i.pll};
   assign mon_any = |mon;

   always_comb begin
      if (in_i.loop_nr) veto = in_i.eqpt;
      else              veto = in_i.ret;
   end

   assign core_o.summary   = mon_any & ~veto;
   assign core_o.eqpt_stat = in_i.eqpt & ~in_i.defeat;

endmodule

// File: rtl/afc_outreg.sv
module afc_outreg
   import afc_pkg::*;
#(
   parameter bit OUT_REG = 1'b1
) (
   input  logic      clk,
   input  logic      rst_n,
   input  afc_core_t core_i,
   output logic      meter_n_o,
   output logic      oc_fault_o,
   output logic      eqpt_stat_o
);

   if (OUT_REG) begin : g_reg
      logic meter_q, fault_q, eqpt_q;
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            meter_q <= 1'b1;
            fault_q <= 1'b0;
            eqpt_q  <= 1'b0;
         end else begin
            meter_q <= ~core_i.summary;
            fault_q <= core_i.summary;
            eqpt_q  <= core_i.eqpt_stat;
         end
      end
      assign meter_n_o   = meter_q;
      assign oc_fault_o  = fault_q;
      assign eqpt_stat_o = eqpt_q;

      AST_RESET_IDLE: assert property (@(posedge clk) !rst_n |=> (meter_q && !fault_q && !eqpt_q)); // R1
      AST_METER_COMPLEMENT: assert property (@(posedge clk) disable iff (!rst_n) meter_q != fault_q); // R6
   end else begin : g_comb
      assign meter_n_o   = ~core_i.summary;
      assign oc_fault_o  = core_i.summary;
      assign eqpt_stat_o = core_i.eqpt_stat;
   end

endmodule

// File: rtl/alarm_fault_combiner.sv
module alarm_fault_combiner
   import afc_pkg::*;
#(
   parameter int unsigned SYNC_STAGES = 2,
   parameter bit          OUT_REG     = 1'b1
) (
   input  logic clk,
   input  logic rst_n,
   input  logic eqpt_fault_i,
   input  logic diag_defeat_i,
   input  logic tx_fail_i,
   input  logic ow_fail_i,
   input  logic pll_alarm_i,
   input  logic ret_fail_i,
   input  logic loop_not_radio_i,
   output logic meter_drive_n_o,
   output logic oc_fault_o,
   output logic eqpt_status_o
);

   localparam int unsigned LATENCY = SYNC_STAGES + (OUT_REG ? 1 : 0);

   if (LATENCY < 2) begin : g_chk_lat
      $error("alarm_fault_combiner: latency below synchronizer minimum");
   end

   afc_in_t   raw_in;
   afc_in_t   syn_in;
   afc_core_t core;
   logic [AFC_IN_W-1:0] syn_bits;

   assign raw_in = '{eqpt:    eqpt_fault_i,
                     defeat:  diag_defeat_i,
                     tx:      tx_fail_i,
                     ow:      ow_fail_i,
                     pll:     pll_alarm_i,
                     ret:     ret_fail_i,
                     loop_nr: loop_not_radio_i};

   afc_sync #(
      .WIDTH   (AFC_IN_W),
      .STAGES  (SYNC_STAGES),
      .RST_VAL (AFC_IN_IDLE)
   ) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d_i   (raw_in),
      .q_o   (syn_bits)
   );

   assign syn_in = afc_in_t'(syn_bits);

   afc_qualify #(
      .MON_W (3)
   ) u_qual (
      .in_i   (syn_in),
      .core_o (core)
   );

   afc_outreg #(
      .OUT_REG (OUT_REG)
   ) u_out (
      .clk         (clk),
      .rst_n       (rst_n),
      .core_i      (core),
      .meter_n_o   (meter_drive_n_o),
      .oc_fault_o  (oc_fault_o),
      .eqpt_stat_o (eqpt_status_o)
   );

   if (OUT_REG) begin : g_sva
      AST_DEFEAT_INHIBITS: assert property (@(posedge clk) disable iff (!rst_n) syn_in.defeat |=> !eqpt_status_o); // R2
      AST_EQPT_REPORTS: assert property (@(posedge clk) disable iff (!rst_n) (syn_in.eqpt && !syn_in.defeat) |=> eqpt_status_o); // R2
      AST_EQPT_VETO: assert property (@(posedge clk) disable iff (!rst_n) (syn_in.loop_nr && syn_in.eqpt) |=> !oc_fault_o); // R3
      AST_RET_VETO: assert property (@(posedge clk) disable iff (!rst_n) (!syn_in.loop_nr && syn_in.ret) |=> !oc_fault_o); // R4
      AST_NO_MON_NO_FAULT: assert property (@(posedge clk) disable iff (!rst_n) !(syn_in.tx || syn_in.ow || syn_in.pll) |=> !oc_fault_o); // R5
   end

endmodule

// File: tb/sim_alarm_fault_combiner.sv
`timescale 1ns/1ps
module sim_alarm_fault_combiner;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic eqpt, defeat, tx, ow, pll, ret, loop_nr;
   logic meter_n, oc_fault, eqpt_stat;

   int n_cmp = 0;
   int n_bad = 0;
   bit done  = 1'b0;

   always #10 clk = ~clk;

   alarm_fault_combiner u0 (
      .clk              (clk),
      .rst_n            (rst_n),
      .eqpt_fault_i     (eqpt),
      .diag_defeat_i    (defeat),
      .tx_fail_i        (tx),
      .ow_fail_i        (ow),
      .pll_alarm_i      (pll),
      .ret_fail_i       (ret),
      .loop_not_radio_i (loop_nr),
      .meter_drive_n_o  (meter_n),
      .oc_fault_o       (oc_fault),
      .eqpt_status_o    (eqpt_stat)
   );

   // behavioural model: queue of pending input vectors {eqpt,defeat,tx,ow,pll,ret,loop}
   logic [6:0] pend[$];
   logic       exp_fault = 1'b0;
   logic       exp_stat  = 1'b0;
   logic       exp_rst   = 1'b1;
   logic       exp_loop  = 1'b0;

   function automatic logic ref_summary(input logic [6:0] v);
      logic any_mon;
      any_mon = v[4] | v[3] | v[2];
      if (!any_mon) return 1'b0;                 // R5
      if (v[0]) return (v[6] == 1'b0);           // R3, R8
      return (v[1] == 1'b0);                     // R4, R8
   endfunction

   initial begin
      pend.push_back(7'd0);
      pend.push_back(7'd0);
   end

   always @(posedge clk) begin
      logic [6:0] cur;
      cur = {eqpt, defeat, tx, ow, pll, ret, loop_nr};
      if (!rst_n) begin
         exp_fault = 1'b0;
         exp_stat  = 1'b0;
         exp_rst   = 1'b1;
         pend.delete();
         pend.push_back(7'd0);
         pend.push_back(7'd0);
      end else begin
         logic [6:0] old;
         old       = pend.pop_front();
         exp_fault = ref_summary(old);
         exp_stat  = old[6] & ~old[5];
         exp_loop  = old[0];
         exp_rst   = 1'b0;
         pend.push_back(cur);
      end
   end

   task automatic check_outputs();
      string tag;
      n_cmp++;
      if (exp_rst) tag = "R1";
      else tag = exp_loop ? "R3/R7" : "R4/R7";
      if (oc_fault !== exp_fault) begin
         n_bad++;
         $display("FAIL %s oc_fault actual=%b expected=%b t=%0t", tag, oc_fault, exp_fault, $time);
      end
      if (meter_n !== ~exp_fault) begin
         n_bad++;
         $display("FAIL R6 meter_n actual=%b expected=%b t=%0t", meter_n, ~exp_fault, $time);
      end
      if (eqpt_stat !== exp_stat) begin
         n_bad++;
         $display("FAIL R2 eqpt_stat actual=%b expected=%b t=%0t", eqpt_stat, exp_stat, $time);
      end
   endtask

   task automatic drive(input logic [6:0] v);
      {eqpt, defeat, tx, ow, pll, ret, loop_nr} = v;
   endtask

   // compare at every falling edge, before new stimulus is applied
   always @(negedge clk) if (!done) check_outputs();

   initial begin : watchdog
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog expired");
         done = 1'b1;
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
         $finish;
      end
   end

   initial begin : stim
      drive(7'b1111111);
      repeat (4) @(negedge clk);              // R1: outputs healthy while in reset
      #1 rst_n = 1'b1;
      drive(7'd0);
      // exhaustive sweep, each combination held to settle (R2..R6, R8)
      for (int i = 0; i < 128; i++) begin
         @(negedge clk); #1;
         drive(i[6:0]);
         repeat (3) @(negedge clk);
         #1;
      end
      // per-cycle toggling incl. mode handover (R7)
      for (int k = 0; k < 600; k++) begin
         @(negedge clk); #1;
         drive(7'($urandom));
         if (k == 300) rst_n = 1'b0;          // R1 mid-run
         if (k == 302) rst_n = 1'b1;
      end
      // directed veto handover: failure present, switch flips (R3, R4, R8)
      @(negedge clk); #1; drive(7'b1010001);
      repeat (4) @(negedge clk); #1; drive(7'b1010000);
      repeat (4) @(negedge clk); #1; drive(7'b0010010);
      repeat (4) @(negedge clk); #1; drive(7'b0010011);
      repeat (5) @(negedge clk);
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule